// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Byte Bypass

This block is a single-clock synchronous memory built from a small register array. A command (select, write flag, address and four byte-lane enables) is taken on one rising edge. For a write, the data word follows on the next rising edge and lands in a one-entry write buffer rather than in the array. The buffered word is only stored into the array when the data of the next write arrives. Reads are pipelined: the word appears in an output register one edge after the read command was taken.

Because the newest write lives in the buffer, a read of the buffered address is assembled lane by lane. Lanes whose enable was set in that write come from the buffer, and the other lanes come from the array. A sleep input freezes the whole interface. While it is high the output is disabled and nothing is taken in, but the stored contents survive. The data bus is split into an input word, an output word and an output-enable flag. A low enable stands for a high-impedance bus.

Top module: `lw_sram`

## Requirements
- R1: A read command (sel=1, wr=0) taken on edge N drives its word on rdata_out with rdata_oe=1 after edge N+1, and rdata_oe is still 0 between edges N and N+1.
- R2: The data of a write command taken on edge N is sampled from wdata_in on edge N+1. The value on wdata_in at edge N has no effect.
- R3: A write is held in the buffer and is stored into the array only when the data of the next write is taken. It then stays readable at its address after later writes to other addresses.
- R4: A read of the buffered address with all four lane enables set in that write returns the buffered word.
- R5: Bypass works per lane, where lane i is bits [9i+8:9i]. For a read of the buffered address, lanes enabled in the buffered write come from the buffer and the rest come from the array.
- R6: When a write is stored into the array, only lanes whose enable was 1 change. Lanes whose enable was 0 keep their earlier contents.
- R7: Two consecutive reads of the same address, with no other command between them, keep rdata_out constant.
- R8: While sleep=1, rdata_oe=0 and rdata_out does not change. Commands presented during sleep have no effect, and stored data is unchanged after sleep ends.
- R9: A cycle that is not a read (deselect or write) drives rdata_oe low one edge later and leaves rdata_out unchanged. A deselect neither stores nor clears the buffer.
- R10: After reset, rdata_oe=0, rdata_out=0, the buffer is empty and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Freeze interface and disable output |
| sel | input | 1 | Command select |
| wr | input | 1 | 1 = write command, 0 = read command |
| be | input | LANES | Per-lane write enables, taken with the command |
| addr | input | AW | Word address |
| wdata_in | input | LANES*LANE_W | Write data, sampled one edge after its command |
| rdata_out | output | LANES*LANE_W | Output register |
| rdata_oe | output | 1 | Output enable; 0 means bus released |

## Verification
The bench builds the block with AW=3 and keeps the four 9-bit lanes, so the array has eight words. This lets a sweep write every address with every one of the sixteen lane-enable patterns. Each write is followed by a bypass read of the buffered address and a read of a neighbouring address that holds earlier stored data. As a result, every merge pattern of buffer and array lanes, and every partial store into the array, is compared against a model computed arithmetically in the bench. Directed sequences then cover latency, repeated reads, deselect and sleep.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sleep,
  input  logic                      sel,
  input  logic                      wr,
  input  logic [LANES-1:0]          be,
  input  logic [AW-1:0]             addr,
  input  logic [LANES*LANE_W-1:0]   wdata_in,
  output logic [LANES*LANE_W-1:0]   rdata_out,
  output logic                      rdata_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             wq, rq, vq;
  logic [AW-1:0]    aq;
  logic [LANES-1:0] beq;
  logic             hv;
  logic [AW-1:0]    ha;
  logic [LANES-1:0] hbe;
  logic [DW-1:0]    hd;
  logic [DW-1:0]    dq;
  logic [DW-1:0]    merged;

  wire rd_cmd  = !sleep && sel && !wr;
  wire wr_cmd  = !sleep && sel && wr;
  wire take_wd = wq && !sleep;
  wire hit     = hv && (ha == aq);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (hit && hbe[l]) ? hd[l*LANE_W +: LANE_W]
                                                        : mem[aq][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq <= 1'b0; rq <= 1'b0; vq <= 1'b0;
      aq <= '0; beq <= '0;
      hv <= 1'b0; ha <= '0; hbe <= '0; hd <= '0;
      dq <= '0;
    end else begin
      wq <= wr_cmd;
      rq <= rd_cmd;
      vq <= rq && !sleep;
      if (sel && !sleep) begin
        aq  <= addr;
        beq <= be;
      end
      if (take_wd) begin
        hv  <= 1'b1;
        ha  <= aq;
        hbe <= beq;
        hd  <= wdata_in;
      end
      if (rq && !sleep) dq <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (take_wd && hv) begin
      for (int l = 0; l < LANES; l++)
        if (hbe[l]) mem[ha][l*LANE_W +: LANE_W] <= hd[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_out = dq;
  assign rdata_oe  = vq && !sleep;
endmodule

module lw_sram_chk #(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata_out,
  input logic          rdata_oe
);
  logic          c1_rd, c2_rd;
  logic [AW-1:0] c1_a, c2_a;
  wire rd_in = sel && !wr && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_rd <= 1'b0; c2_rd <= 1'b0; c1_a <= '0; c2_a <= '0;
    end else begin
      c1_rd <= rd_in; c1_a <= addr;
      c2_rd <= c1_rd; c2_a <= c1_a;
    end
  end

  p_oe_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in ##1 !sleep |=> (rdata_oe || sleep));

  p_reread_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_rd && c2_rd && c1_a == c2_a && !sleep) |=> $stable(rdata_out));

  p_sleep_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(rdata_out));

  p_idle_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in |=> ##1 !rdata_oe);

  p_idle_holds_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in |=> ##1 $stable(rdata_out));
endmodule

bind lw_sram lw_sram_chk #(.AW(AW), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel(sel), .wr(wr),
  .addr(addr), .rdata_out(rdata_out), .rdata_oe(rdata_oe)
);

// File: tb/sim_lw_sram.sv
module sim_lw_sram;
  localparam int AW = 3, LANES = 4, LW = 9, DW = 36, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [LANES-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata_in = '0;
  logic [DW-1:0] rdata_out;
  logic rdata_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] mm [DEPTH];
  logic mh_v;
  logic [AW-1:0] mh_a;
  logic [LANES-1:0] mh_be;
  logic [DW-1:0] mh_d;

  always #4 clk = ~clk;

  lw_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel(sel), .wr(wr), .be(be),
    .addr(addr), .wdata_in(wdata_in), .rdata_out(rdata_out), .rdata_oe(rdata_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int a, input int b, input int k);
    logic [DW-1:0] d;
    for (int i = 0; i < LANES; i++) d[i*LW +: LW] = 9'((a*37 + b*11 + i*53 + k*7 + 1) % 512);
    return d;
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] d;
    d = mm[a];
    if (mh_v && mh_a == a)
      for (int i = 0; i < LANES; i++) if (mh_be[i]) d[i*LW +: LW] = mh_d[i*LW +: LW];
    return d;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [LANES-1:0] b, input logic [DW-1:0] d);
    if (mh_v)
      for (int i = 0; i < LANES; i++) if (mh_be[i]) mm[mh_a][i*LW +: LW] = mh_d[i*LW +: LW];
    mh_v = 1'b1; mh_a = a; mh_be = b; mh_d = d;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [LANES-1:0] b, input logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; be = b; addr = a; wdata_in = ~d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; be = ~b; addr = ~a; wdata_in = d;
    model_write(a, b, d);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a; wdata_in = '1;
    @(negedge clk);
    check("R1 oe not early", {35'b0, rdata_oe}, 36'd0);
    sel = 1'b0; addr = ~a;
    @(negedge clk);
    check("R1 oe", {35'b0, rdata_oe}, 36'd1);
    check(req, rdata_out, model_read(a));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    mh_v = 1'b0; mh_a = '0; mh_be = '0; mh_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 oe", {35'b0, rdata_oe}, 36'd0);
    check("R10 data", rdata_out, '0);
    do_read(3'd5, "R10 array zero");

    // R2 R4 full-word write then bypass
    do_write(3'd1, 4'hF, 36'h123456789);
    do_read(3'd1, "R2 R4 bypass full");

    // R3 R5 R6 sweep over addresses and lane patterns
    for (int a = 0; a < DEPTH; a++)
      for (int b = 0; b < 16; b++) begin
        do_write(AW'(a), LANES'(b), pattern(a, b, 0));
        do_read(AW'(a), "R5 lane merge");
        do_read(AW'((a + 3) % DEPTH), "R3 R6 stored lanes");
      end

    // R7 back-to-back reads
    do_write(3'd6, 4'b0101, 36'hABCDEF012);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = 3'd6;
    @(negedge clk);
    @(negedge clk); sel = 1'b0;
    v = rdata_out;
    check("R7 first", v, model_read(3'd6));
    @(negedge clk);
    check("R7 second", rdata_out, v);
    check("R7 oe", {35'b0, rdata_oe}, 36'd1);

    // R9 deselect keeps output and buffer
    @(negedge clk); sel = 1'b0; wr = 1'b1; be = 4'hF; addr = 3'd2; wdata_in = '1;
    @(negedge clk);
    check("R9 oe low", {35'b0, rdata_oe}, 36'd0);
    check("R9 data held", rdata_out, v);
    @(negedge clk); wr = 1'b0;
    do_read(3'd6, "R9 buffer kept");
    do_read(3'd2, "R9 no store");

    // R8 sleep
    do_write(3'd4, 4'hF, 36'h0F0F0F0F0);
    do_read(3'd4, "R8 before sleep");
    v = rdata_out;
    @(negedge clk); sleep = 1'b1; sel = 1'b1; wr = 1'b1; be = 4'hF; addr = 3'd4;
    for (int i = 0; i < 4; i++) begin
      wdata_in = 36'h111111111 * (i + 1);
      @(negedge clk);
      check("R8 oe low", {35'b0, rdata_oe}, 36'd0);
      check("R8 data frozen", rdata_out, v);
      wr = i[0];
    end
    sleep = 1'b0; sel = 1'b0; wr = 1'b0;
    do_read(3'd4, "R8 contents kept");
    do_read(3'd7, "R8 array kept");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule